// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block takes an asynchronous DRAM array from power-up to normal use and then keeps its contents alive. It times out a power-up pause, runs a fixed number of CAS-before-RAS cycles without asking anyone, and raises `init_done`. From then on it counts a refresh interval. Each expiry adds one entry to a small pending count. While anything is pending it asks the access controller for a slot through `refresh_req` / `refresh_gnt`. The device's internal row counter picks the row, so no refresh address is produced. Every strobe cycle drives all row strobes together and all column strobes together, with the column strobes leading. Write enable stays high.

The control state machine has five states. PAUSE moves to INIT when the pause timer expires. INIT moves to IDLE when the last initialisation cycle completes. IDLE moves to REQ when a refresh is pending. REQ moves to REFRESH on a grant. REFRESH returns to REQ if more refreshes are pending, or to IDLE if none are. A second state machine produces the strobe waveform. It runs from S_IDLE to COL_SETUP, where the column strobes are low. It then goes to ROW_ACTIVE, where both strobes are low, then to PRECHARGE, where all strobes are high, and back to S_IDLE. Each phase lasts a parameterised number of clocks.

Top module: `dram_rfsh_init`

## Requirements
- R1: During and right after reset, every `ras_n` and `cas_n` bit and `we_n` are 1, and `refresh_req`, `busy`, `init_done` and `refresh_urgent` are 0.
- R2: No strobe goes low before more than PAUSE_CYC clock cycles have passed since reset was released.
- R3: After the pause, exactly INIT_CYCLES strobe cycles run with no grant needed. `init_done` then rises and stays high until reset.
- R4: In every strobe cycle the column strobes fall at least CSR_CYC cycles before the row strobes fall. They stay low for as long as the row strobes are low, and they rise together with them.
- R5: The row strobes stay low for at least RAS_CYC cycles. They stay high for at least RP_CYC cycles before the column strobes fall again.
- R6: `we_n` is 1 at all times.
- R7: All bits of `ras_n` carry the same value, and all bits of `cas_n` carry the same value.
- R8: Once `init_done` is high, one pending refresh is added every INTERVAL_CYC cycles. `refresh_req` is 1 whenever the sequencer is waiting for a grant with a refresh pending.
- R9: After initialisation, strobes move only after a grant. A grant sampled while `refresh_req` is 1 starts exactly one strobe cycle and retires one pending refresh. `refresh_req` is low while strobes are active.
- R10: The pending count saturates at MAX_PEND. Further interval expiries are lost, so after a long denial at most MAX_PEND refreshes follow.
- R11: `refresh_urgent` is 1 exactly when URGENT_LVL or more refreshes are pending.
- R12: `busy` is 1 in every cycle in which any row or column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_gnt | input | 1 | Access controller grants the refresh slot |
| refresh_req | output | 1 | A refresh is pending and waiting for a grant |
| refresh_urgent | output | 1 | Pending count has reached the urgency level |
| busy | output | 1 | An initialisation or refresh strobe cycle is running |
| init_done | output | 1 | Power-up pause and initialisation cycles are complete |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, held inactive high |

## Verification
The bench builds the block with a 40-cycle pause, 8 initialisation cycles, a 120-cycle refresh interval and strobe phases of 1, 3 and 2 clocks. The short pause and interval let a denied grant pile up ten interval expiries within a few thousand cycles. That run reaches pending-count saturation and both sides of the urgency threshold. The 8 initialisation cycles and the 8-deep pending limit keep their default values, so the counts checked are the ones used in real operation.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        TOP_PAUSE,
        TOP_INIT,
        TOP_IDLE,
        TOP_REQ,
        TOP_RFSH
    } top_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_COL_SETUP,
        SEQ_ROW_ACTIVE,
        SEQ_PRECHARGE
    } seq_state_t;

endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
    parameter int PERIOD = 770
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the counter never runs past its last value
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int MAX_PEND   = 8,
    parameter int URGENT_LVL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic pend_any,
    output logic urgent
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] TOP_VAL = PW'(MAX_PEND);
    localparam logic [PW-1:0] URG_VAL = PW'(URGENT_LVL);

    logic [PW-1:0] cnt;
    logic [PW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        unique case ({inc, dec})
            2'b10:   cnt_nxt = (cnt == TOP_VAL) ? cnt : cnt + 1'b1;
            2'b01:   cnt_nxt = (cnt == '0) ? cnt : cnt - 1'b1;
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    assign pend_any = (cnt != '0);
    assign urgent   = (cnt >= URG_VAL);

    // R10: the pending count never exceeds the limit
    p_pend_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_VAL);

    // R10: a new expiry at the limit leaves the count at the limit
    p_pend_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt == TOP_VAL) |=> (cnt == TOP_VAL));

    // R8: the count moves only on an expiry or a grant
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(cnt));

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int RP_CYC  = 2,
    parameter int NUM_RAS = 2,
    parameter int NUM_CAS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               idle,
    output logic               done,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n
);
    localparam int MAXPH = (CSR_CYC > RAS_CYC) ?
                           ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC) :
                           ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
    localparam int CW = $clog2(MAXPH + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          ras_q, cas_q;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + 1'b1;
        done    = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                cnt_nxt = '0;
                if (start) nxt = SEQ_COL_SETUP;
            end
            SEQ_COL_SETUP: begin
                if (cnt == CSR_LAST) begin
                    nxt     = SEQ_ROW_ACTIVE;
                    cnt_nxt = '0;
                end
            end
            SEQ_ROW_ACTIVE: begin
                if (cnt == RAS_LAST) begin
                    nxt     = SEQ_PRECHARGE;
                    cnt_nxt = '0;
                end
            end
            SEQ_PRECHARGE: begin
                if (cnt == RP_LAST) begin
                    nxt     = SEQ_IDLE;
                    cnt_nxt = '0;
                    done    = 1'b1;
                end
            end
            default: begin
                nxt     = SEQ_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            ras_q <= (nxt != SEQ_ROW_ACTIVE);
            cas_q <= !((nxt == SEQ_COL_SETUP) || (nxt == SEQ_ROW_ACTIVE));
        end
    end

    assign idle = (state == SEQ_IDLE);

    for (genvar gi = 0; gi < NUM_RAS; gi++) begin : g_ras
        assign ras_n[gi] = ras_q;
    end
    for (genvar gj = 0; gj < NUM_CAS; gj++) begin : g_cas
        assign cas_n[gj] = cas_q;
    end

    // R4: the column strobe was already low in the cycle before the row strobe falls
    p_col_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_q) |-> (!cas_q && $past(!cas_q)));

    // R4: the column strobe is held low for as long as the row strobe is low
    p_col_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_q |-> !cas_q);

    // R5: the row strobe goes high straight into precharge
    p_pre_after_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_q) |-> (state == SEQ_PRECHARGE));

endmodule

// File: rtl/dram_rfsh_init.sv
module dram_rfsh_init
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 10000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 770,
    parameter int CSR_CYC      = 1,
    parameter int RAS_CYC      = 3,
    parameter int RP_CYC       = 2,
    parameter int MAX_PEND     = 8,
    parameter int URGENT_LVL   = 4,
    parameter int NUM_RAS      = 2,
    parameter int NUM_CAS      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               refresh_gnt,
    output logic               refresh_req,
    output logic               refresh_urgent,
    output logic               busy,
    output logic               init_done,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

    top_state_t    state, nxt;
    logic [IW-1:0] init_cnt;
    logic          pause_tick, ival_tick;
    logic          seq_start, seq_idle, seq_done;
    logic          pend_dec, pend_any;

    rfsh_tick #(.PERIOD(PAUSE_CYC)) u_pause (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == TOP_PAUSE),
        .tick (pause_tick)
    );

    rfsh_tick #(.PERIOD(INTERVAL_CYC)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (init_done),
        .tick (ival_tick)
    );

    rfsh_pending #(.MAX_PEND(MAX_PEND), .URGENT_LVL(URGENT_LVL)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (ival_tick),
        .dec     (pend_dec),
        .pend_any(pend_any),
        .urgent  (refresh_urgent)
    );

    rfsh_strobe_seq #(
        .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
        .NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(seq_start),
        .idle (seq_idle),
        .done (seq_done),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    // next state and strobe-launch decisions
    always_comb begin
        nxt       = state;
        seq_start = 1'b0;
        pend_dec  = 1'b0;
        unique case (state)
            TOP_PAUSE: if (pause_tick) nxt = TOP_INIT;
            TOP_INIT: begin
                seq_start = seq_idle;
                if (seq_done && init_cnt == INIT_LAST) nxt = TOP_IDLE;
            end
            TOP_IDLE: if (pend_any) nxt = TOP_REQ;
            TOP_REQ: begin
                if (refresh_gnt) begin
                    nxt       = TOP_RFSH;
                    seq_start = 1'b1;
                    pend_dec  = 1'b1;
                end
            end
            TOP_RFSH: if (seq_done) nxt = pend_any ? TOP_REQ : TOP_IDLE;
            default: nxt = TOP_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TOP_PAUSE;
            init_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == TOP_INIT && seq_done) init_cnt <= init_cnt + 1'b1;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        refresh_req = (state == TOP_REQ);
        busy        = (state == TOP_INIT) || (state == TOP_RFSH);
        init_done   = (state == TOP_IDLE) || (state == TOP_REQ) || (state == TOP_RFSH);
        we_n        = 1'b1;
    end

    // R2: the strobes stay inactive during the power-up pause
    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TOP_PAUSE) |-> ((&ras_n) && (&cas_n)));

    // R3: once raised, init_done stays high
    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9: no strobe is active while a grant is awaited
    p_no_strobe_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> ((&ras_n) && (&cas_n)));

    // R9: an accepted grant begins a column-first cycle on the next edge
    p_grant_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && refresh_gnt) |=> (busy && !cas_n[0] && ras_n[0]));

    // R12: any low strobe is covered by busy
    p_busy_covers_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n[0] || !cas_n[0]) |-> busy);

endmodule

// File: tb/tb_dram_rfsh_init.sv
module tb_dram_rfsh_init;
    localparam int PAUSE    = 40;
    localparam int INITN    = 8;
    localparam int INTERVAL = 120;
    localparam int CSR      = 1;
    localparam int RASW     = 3;
    localparam int RP       = 2;
    localparam int MAXP     = 8;
    localparam int URG      = 4;
    localparam int NR       = 2;
    localparam int NC       = 4;

    // rows: {interval expiries while denied, expected refreshes, expected urgent}
    localparam int ROWS = 4;
    localparam int TBL [ROWS][3] = '{
        '{1, 1, 0},
        '{3, 3, 0},
        '{4, 4, 1},
        '{10, 8, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_gnt = 1'b0;
    logic          refresh_req, refresh_urgent, busy, init_done, we_n;
    logic [NR-1:0] ras_n;
    logic [NC-1:0] cas_n;

    always #10 clk = ~clk;

    dram_rfsh_init #(
        .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .INTERVAL_CYC(INTERVAL),
        .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP),
        .MAX_PEND(MAXP), .URGENT_LVL(URG), .NUM_RAS(NR), .NUM_CAS(NC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt),
        .refresh_req(refresh_req), .refresh_urgent(refresh_urgent),
        .busy(busy), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // port monitor, sampled at the falling edge
    int  cyc = 0;
    int  ras_falls = 0;
    int  first_fall = -1;
    int  ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
    int  falls_at_init = -1;
    int  v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r12 = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_init = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ras_n != {NR{ras_n[0]}} || cas_n != {NC{cas_n[0]}}) v_r7++;
            if (we_n !== 1'b1) v_r6++;
            if ((!ras_n[0] || !cas_n[0]) && !busy) v_r12++;
            if (first_fall < 0 && (!ras_n[0] || !cas_n[0])) first_fall = cyc;
            // column strobe falling: precharge behind it
            if (prev_cas && !cas_n[0] && ras_high_run < RP && ras_falls > 0) v_r5++;
            // row strobe falling: column strobe led it
            if (prev_ras && !ras_n[0]) begin
                ras_falls++;
                if (cas_low_run < CSR) v_r4++;
                if (ras_falls > 1 && ras_high_run < RP + CSR) v_r5++;
            end
            // row strobe rising: width and joint column rise
            if (!prev_ras && ras_n[0]) begin
                if (ras_low_run < RASW) v_r5++;
                if (!cas_n[0]) v_r4++;
            end
            if (!ras_n[0] && cas_n[0]) v_r4++;
            if (!prev_init && init_done) falls_at_init = ras_falls;
            if (prev_init && !init_done) v_r12++;
            ras_low_run  = ras_n[0] ? 0 : ras_low_run + 1;
            ras_high_run = ras_n[0] ? ras_high_run + 1 : 0;
            cas_low_run  = cas_n[0] ? 0 : cas_low_run + 1;
            prev_ras  = ras_n[0];
            prev_cas  = cas_n[0];
            prev_init = init_done;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int n;
        repeat (3) step();
        // R1: state held by reset
        chk(&ras_n, "R1 ras_n", int'(ras_n), (1 << NR) - 1);
        chk(&cas_n, "R1 cas_n", int'(cas_n), (1 << NC) - 1);
        chk(we_n == 1'b1, "R1 we_n", int'(we_n), 1);
        chk(!refresh_req && !busy, "R1 req/busy", int'({refresh_req, busy}), 0);
        chk(!init_done && !refresh_urgent, "R1 init/urgent", int'({init_done, refresh_urgent}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk(&ras_n && &cas_n && !busy, "R1 after release", int'({ras_n, cas_n}), (1 << (NR + NC)) - 1);

        while (!init_done) step();
        // R2: quiet pause
        chk(first_fall > PAUSE, "R2 first strobe cycle", first_fall, PAUSE + 1);
        // R3: initialisation count
        chk(falls_at_init == INITN, "R3 init cycles", falls_at_init, INITN);
        chk(!refresh_req, "R3 no request at init end", int'(refresh_req), 0);

        // table of denial lengths walked by one loop
        for (int r = 0; r < ROWS; r++) begin
            n = TBL[r][0];
            refresh_gnt = 1'b0;
            while (!refresh_req) step();
            base = ras_falls;
            repeat ((n - 1) * INTERVAL + 10) step();
            chk(ras_falls == base, "R9 quiet without grant", ras_falls - base, 0);
            chk(refresh_req == 1'b1, "R8 request held", int'(refresh_req), 1);
            chk(int'(refresh_urgent) == TBL[r][2], "R11 urgent level", int'(refresh_urgent), TBL[r][2]);
            refresh_gnt = 1'b1;
            step();
            while (refresh_req || busy) step();
            refresh_gnt = 1'b0;
            chk(ras_falls - base == TBL[r][1], "R10 refreshes after denial", ras_falls - base, TBL[r][1]);
            chk(!refresh_urgent, "R11 urgent cleared", int'(refresh_urgent), 0);
        end

        // R3: init_done never dropped
        chk(init_done == 1'b1, "R3 init_done sticky", int'(init_done), 1);
        // R8: with no grant, next request arrives within one interval
        base = 0;
        while (!refresh_req && base < INTERVAL + 5) begin
            step();
            base++;
        end
        chk(refresh_req == 1'b1, "R8 periodic request", int'(refresh_req), 1);

        chk(v_r4 == 0, "R4 column-before-row order", v_r4, 0);
        chk(v_r5 == 0, "R5 width and precharge", v_r5, 0);
        chk(v_r6 == 0, "R6 write enable high", v_r6, 0);
        chk(v_r7 == 0, "R7 strobes identical", v_r7, 0);
        chk(v_r12 == 0, "R12 busy covers strobes", v_r12, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule